// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block takes a single-rank SDR SDRAM from power-up to a usable state, then hands periodic refresh requests to the host's command arbiter. A `start` pulse sets it going. It raises clock enable and waits a start-up delay. It then precharges every bank and waits the row-precharge time. Next it issues a fixed number of auto-refresh commands, each followed by a recovery gap, and then loads the mode register. The mode word travels on the address pins. After the mode-register delay it raises `init_done`. From then on it leaves the command pins deselected.

If `refresh_on` is high when the start pulse arrives, refresh is already running and the device needs no bring-up. The whole sequence is skipped and the block goes straight to its initialized state. Once initialized, an interval counter produces a one-cycle `refresh_req` each time it expires. It then holds until the arbiter answers with `refresh_ack`, which reloads the interval. All timings are parameters counted in bus clocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and until a start pulse is accepted: `cke`=0, `cs_n`/`ras_n`/`cas_n`/`we_n` all 1, `init_done`=0, `refresh_req`=0.
- R2: A start pulse seen in the idle state with `refresh_on`=0 raises `cke` from the next cycle. The precharge-all command appears exactly T_STARTUP cycles after that first `cke` cycle.
- R3: Precharge-all is driven as `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0 with address bit 10 = 1.
- R4: The first auto-refresh comes T_RP+1 cycles after the precharge-all cycle, with T_RP deselected cycles between them.
- R5: Exactly N_REFRESH auto-refresh commands are issued (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1). Consecutive ones are T_RFC+1 cycles apart, and the mode load follows the last one after T_RFC+1 cycles.
- R6: The mode load is driven as `cs_n`/`ras_n`/`cas_n`/`we_n` all 0, with `ba`=0 and address = CAS_LAT·16. In that word, bits 2:0 = 0 (burst length 1), bit 3 = 0 (sequential), bits 6:4 = CAS latency, bits 8:7 = 0 (standard operation) and bit 9 = 0 (write burst follows the programmed length).
- R7: `init_done` first goes high T_MRD+1 cycles after the mode-load cycle and stays high until reset. No command is issued once it is high.
- R8: A start pulse with `refresh_on`=1 sets `init_done` in the following cycle and issues no command.
- R9: `refresh_req` is a one-cycle pulse, first seen T_REFI cycles after the first `init_done` cycle.
- R10: After a request, no further request appears until `refresh_ack` is sampled. The next request follows T_REFI cycles after the ack's sampling edge.
- R11: A `refresh_ack` with no request pending has no effect, and a `start` pulse outside the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request the bring-up sequence |
| refresh_on | input | 1 | Refresh already running; skip bring-up |
| refresh_ack | input | 1 | Arbiter has served the pending refresh |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address pins, carrying the mode word during mode load |
| init_done | output | 1 | Device initialized |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
The bench builds two copies with compressed timings: T_STARTUP=20, T_RP=3, T_RFC=4, N_REFRESH=8, T_MRD=2, T_REFI=30. One copy uses CAS latency 3 and the other CAS latency 2, so both mode words are checked in a single run. The short timings make it cheap to log every command cycle. Each gap in the full sequence is then compared against its arithmetic value, along with several refresh-handshake rounds with different ack delays and the skip path after a second reset.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int T_STARTUP = 5000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int N_REFRESH = 8,
  parameter int T_MRD     = 2,
  parameter int T_REFI    = 780,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              refresh_on,
  input  logic              refresh_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req
);

  localparam int MAXT = (T_STARTUP > T_RFC) ? T_STARTUP : T_RFC;
  localparam int CW   = $clog2(MAXT + 1) + 1;
  localparam int RW   = $clog2(T_REFI + 1) + 1;
  localparam int NW   = $clog2(N_REFRESH + 1) + 1;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PRE, S_TRP, S_REF, S_TRFC, S_MRS, S_TMRD, S_DONE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [NW-1:0] nref;
  logic [RW-1:0] rcnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      nref        <= '0;
      rcnt        <= '0;
      pend        <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      refresh_req <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (refresh_on) begin
            state <= S_DONE;
            rcnt  <= RW'(T_REFI - 1);
          end else begin
            state <= S_PWR;
            cnt   <= CW'(T_STARTUP - 1);
          end
        end
        S_PWR: if (cnt == 0) state <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE: begin
          state <= S_TRP;
          cnt   <= CW'(T_RP - 1);
        end
        S_TRP: if (cnt == 0) begin
          state <= S_REF;
          nref  <= '0;
        end else cnt <= cnt - 1'b1;
        S_REF: begin
          state <= S_TRFC;
          cnt   <= CW'(T_RFC - 1);
          nref  <= nref + 1'b1;
        end
        S_TRFC: if (cnt == 0) state <= (nref == NW'(N_REFRESH)) ? S_MRS : S_REF;
                else cnt <= cnt - 1'b1;
        S_MRS: begin
          state <= S_TMRD;
          cnt   <= CW'(T_MRD - 1);
        end
        S_TMRD: if (cnt == 0) begin
          state <= S_DONE;
          rcnt  <= RW'(T_REFI - 1);
          pend  <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_DONE: begin
          if (pend) begin
            if (refresh_ack) begin
              pend <= 1'b0;
              rcnt <= RW'(T_REFI - 1);
            end
          end else if (rcnt == 0) begin
            refresh_req <= 1'b1;
            pend        <= 1'b1;
          end else rcnt <= rcnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cke       = (state != S_IDLE);
  assign init_done = (state == S_DONE);
  assign ba        = '0;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    addr = '0;
    case (state)
      S_PRE: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0010;
        addr[10] = 1'b1;
      end
      S_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      S_MRS: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr = MODE_WORD;
      end
      default: ;
    endcase
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n && !init_done && !refresh_req));

  a_r3_pre_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);

  a_r4_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |=> cs_n);

  a_r6_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr == MODE_WORD && ba == '0));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r7_no_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cs_n);

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  a_r9_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int TS = 20, TRP = 3, TRFC = 4, NREF = 8, TMRD = 2, TREFI = 30;

  logic clk = 0, rst_n = 0, start = 0, ron = 0, ack = 0, clr = 1;
  logic cke, cs_n, ras_n, cas_n, we_n, done, req;
  logic [1:0] ba;
  logic [11:0] addr;
  logic cke2, cs2, ras2, cas2, we2, done2, req2;
  logic [1:0] ba2;
  logic [11:0] addr2;

  always #4 clk = ~clk;

  sdram_init_seq #(.T_STARTUP(TS), .T_RP(TRP), .T_RFC(TRFC), .N_REFRESH(NREF),
    .T_MRD(TMRD), .T_REFI(TREFI), .CAS_LAT(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .refresh_on(ron), .refresh_ack(ack),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(done), .refresh_req(req));

  sdram_init_seq #(.T_STARTUP(TS), .T_RP(TRP), .T_RFC(TRFC), .N_REFRESH(NREF),
    .T_MRD(TMRD), .T_REFI(TREFI), .CAS_LAT(2)) uut_cl2 (
    .clk(clk), .rst_n(rst_n), .start(start), .refresh_on(ron), .refresh_ack(ack),
    .cke(cke2), .cs_n(cs2), .ras_n(ras2), .cas_n(cas2), .we_n(we2),
    .ba(ba2), .addr(addr2), .init_done(done2), .refresh_req(req2));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_ev, nr, done_cyc, cke_cyc;
  logic done_seen, cke_seen;
  logic [2:0] ev_kind [16];
  int ev_cyc [16];
  logic [11:0] ev_addr [16];
  logic [1:0] ev_ba [16];
  int rq_cyc [8];
  logic [11:0] mrs2_addr;

  always @(negedge clk) begin
    if (clr) begin
      n_ev = 0; nr = 0; done_seen = 0; cke_seen = 0;
      done_cyc = -1; cke_cyc = -1; mrs2_addr = 12'hfff;
    end else begin
      if (!cs_n && n_ev < 16) begin
        ev_kind[n_ev] = {ras_n, cas_n, we_n};
        ev_cyc[n_ev] = cyc; ev_addr[n_ev] = addr; ev_ba[n_ev] = ba;
        n_ev++;
      end
      if (req && nr < 8) begin rq_cyc[nr] = cyc; nr++; end
      if (done && !done_seen) begin done_seen = 1; done_cyc = cyc; end
      if (cke && !cke_seen) begin cke_seen = 1; cke_cyc = cyc; end
      if (!cs2 && {ras2, cas2, we2} == 3'b000) mrs2_addr = addr2;
    end
  end

  int checks = 0, fails = 0;
  logic finished = 0;

  task automatic chk(input logic ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, p, m, d, e;
    repeat (3) @(negedge clk);
    chk({cke, cs_n, ras_n, cas_n, we_n, done, req} == 7'b0111100, "R1 reset pins",
        {cke, cs_n, ras_n, cas_n, we_n, done, req}, 7'b0111100);
    rst_n = 1; clr = 0;
    repeat (4) @(negedge clk);
    chk(!cke && !done && cs_n, "R1 idle before start", {cke, done, cs_n}, 3'b001);

    start = 1;
    @(posedge clk); #1 s = cyc;
    @(negedge clk) start = 0;
    wait_until(s + 10);
    ack = 1; @(negedge clk) ack = 0;
    wait_until(s + TS + 6);
    start = 1; @(negedge clk) start = 0;
    while (!done_seen && cyc < s + 400) @(negedge clk);

    chk(cke_cyc == s, "R2 cke rise", cke_cyc, s);
    chk(n_ev == NREF + 2, "R5 command count", n_ev, NREF + 2);
    p = s + TS;
    chk(ev_cyc[0] == p, "R2 precharge time", ev_cyc[0], p);
    chk(ev_kind[0] == 3'b010 && ev_addr[0][10], "R3 precharge encoding",
        {ev_kind[0], ev_addr[0][10]}, 4'b0101);
    for (int i = 0; i < NREF; i++) begin
      chk(ev_kind[1+i] == 3'b001, "R5 refresh encoding", ev_kind[1+i], 3'b001);
      chk(ev_cyc[1+i] == p + 1 + TRP + i * (1 + TRFC), "R4 R5 refresh timing",
          ev_cyc[1+i], p + 1 + TRP + i * (1 + TRFC));
    end
    m = p + 1 + TRP + (NREF - 1) * (1 + TRFC) + 1 + TRFC;
    chk(ev_cyc[NREF+1] == m, "R5 mode load timing", ev_cyc[NREF+1], m);
    chk(ev_kind[NREF+1] == 3'b000 && ev_ba[NREF+1] == 0, "R6 mode load encoding",
        {ev_kind[NREF+1], ev_ba[NREF+1]}, 0);
    chk(ev_addr[NREF+1] == 12'(3 * 16), "R6 mode word CL3", ev_addr[NREF+1], 3 * 16);
    chk(mrs2_addr == 12'(2 * 16), "R6 mode word CL2", mrs2_addr, 2 * 16);
    d = m + 1 + TMRD;
    chk(done_cyc == d, "R7 init_done timing", done_cyc, d);

    wait_until(d + 5);
    ack = 1; @(negedge clk) ack = 0;
    wait_until(d + TREFI + 12);
    chk(nr == 1, "R10 R11 single pending request", nr, 1);
    chk(rq_cyc[0] == d + TREFI, "R9 R11 first request", rq_cyc[0], d + TREFI);
    e = cyc + 1;
    ack = 1; @(negedge clk) ack = 0;
    wait_until(e + TREFI + 3);
    chk(nr == 2 && rq_cyc[1] == e + TREFI, "R10 reload after ack", rq_cyc[1], e + TREFI);
    e = cyc + 1;
    ack = 1; @(negedge clk) ack = 0;
    wait_until(e + TREFI + 1);
    chk(nr == 3 && rq_cyc[2] == e + TREFI, "R10 second reload", rq_cyc[2], e + TREFI);
    chk(n_ev == NREF + 2 && done, "R7 quiet and sticky after done", n_ev, NREF + 2);

    rst_n = 0; clr = 1;
    repeat (2) @(negedge clk);
    chk(!done && !cke && !req, "R1 reset again", {done, cke, req}, 0);
    rst_n = 1; clr = 0; ron = 1; start = 1;
    @(posedge clk); #1 s = cyc;
    @(negedge clk) start = 0;
    chk(done == 1, "R8 skip sets done", done, 1);
    wait_until(s + TREFI + 2);
    chk(done_cyc == s, "R8 skip done cycle", done_cyc, s);
    chk(n_ev == 0, "R8 skip issues no command", n_ev, 0);
    chk(nr == 1 && rq_cyc[0] == s + TREFI, "R9 request after skip", rq_cyc[0], s + TREFI);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule